// File: doc/BRIEF.md
# Synchronous Serial Master with Framed Clock

This block sends and receives characters as the clock-owning side of a synchronous serial link. Each character goes out on the transmit pin framed by a low start bit and a high stop bit. A serial clock is emitted only while data bits are on the line, so a clocked slave sees exactly one clock pulse per data bit. The slave's reply is sampled on the receive pin at the capture edge of the same clock. The word length is 8 or 9 bits. The clock's idle level, its phase and whether the final data bit gets a pulse are all configurable.

Software or a controller loads a word through a parallel port while `tx_busy_o` is low, and the frame starts at once. Bit timing comes from an external baud tick. One bit lasts 16 ticks. Capture always happens 8 ticks into a data bit, so the receive line must be stable for one tick before and after that point. The received word is offered on a parallel port together with a valid flag and an overrun flag.

Top module: `sync_usart_master`

## Requirements
- R1: `cfg_long_i`=1 selects 9 data bits and 0 selects 8. The value is latched at load, and in 8-bit mode bit 8 of `tx_data_i` is not sent.
- R2: A frame on `tx_o` is one 0 bit, then the data bits least-significant first, then one 1 bit. Each bit lasts 16 baud ticks, counted from the clock edge that accepts the load.
- R3: While no frame is in progress, `tx_o` is 1 and `tx_busy_o` is 0. A load is accepted only when `tx_busy_o` is 0, and a load pulse during a frame changes neither that frame nor the following idle state.
- R4: `sclk_o` equals `cfg_cpol_i` (0 gives an idle-low clock, 1 an idle-high clock) outside data bits: at idle, during the start bit and during the stop bit.
- R5: Within a data bit whose tick index runs 0..15, `sclk_o` is at the non-idle level during ticks 8..15 when `cfg_cpha_i`=0, and during ticks 0..7 when `cfg_cpha_i`=1.
- R6: When `cfg_lastclk_i`=0, `sclk_o` stays at its idle level for the whole of the final data bit. When it is 1, the final bit gets a pulse like every other data bit.
- R7: `rx_i` is sampled once per data bit, at the baud tick that moves the tick index from 7 to 8, which is the capture edge for both phase settings. The samples fill `rx_data_o` least-significant first. In 8-bit mode `rx_data_o[8]` is 0.
- R8: `rx_valid_o` goes to 1 in the cycle after the tick that ends the stop bit, and a cycle with `rx_read_i`=1 clears it.
- R9: `rx_overrun_o` goes to 1 when a word completes while `rx_valid_o` is still 1 and not being read. The newer word replaces the older one. `rx_read_i` clears the flag.
- R10: Bit timing advances only on cycles with `baud_tick_i`=1, and any number of idle cycles may separate ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| cfg_long_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_cpol_i | input | 1 | Serial clock idle level |
| cfg_cpha_i | input | 1 | 0: capture on first edge, 1: on second edge |
| cfg_lastclk_i | input | 1 | 1: pulse the clock for the final data bit |
| tx_data_i | input | 9 | Word to send |
| tx_load_i | input | 1 | Start a frame with `tx_data_i` |
| tx_busy_o | output | 1 | Frame in progress |
| rx_data_o | output | 9 | Last received word |
| rx_valid_o | output | 1 | Unread word present |
| rx_read_i | input | 1 | Consume the received word |
| rx_overrun_o | output | 1 | A word was lost |
| tx_o | output | 1 | Serial data out |
| rx_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock out |

## Verification
The assertions check several properties on every cycle. The clock rests at its idle level whenever no frame runs. It stays idle across a suppressed final bit. Each frame opens with a low start bit. The tick counter holds between ticks. The valid and overrun flags rise only after a completed frame, and only while a word is pending. Bit order, the exact tick of every clock edge in both phase settings, the capture instant and the handling of a load during a frame can only be shown by the bench scenarios. The bench compares the whole waveform against a model and drives the receive line correctly only around the capture tick.

// File: rtl/sua_pkg.sv
package sua_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;
endpackage

// File: rtl/sua_frame_ctrl.sv
module sua_frame_ctrl
  import sua_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OSR    = 16,
  localparam int CNT_W = $clog2(OSR),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              long_i,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_bit_o,
  output logic              long_o,
  output logic              cap_o,
  output logic              done_o,
  output logic              tx_o
);
  localparam int HALF = OSR / 2;
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(HALF - 1);
  localparam logic [IDX_W-1:0] IDX_LONG = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHRT = IDX_W'(DATA_W - 2);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              long_q;
  logic              bit_end;
  logic [IDX_W-1:0]  last_idx;

  assign bit_end  = tick_i && (cnt_q == CNT_END);
  assign last_idx = long_q ? IDX_LONG : IDX_SHRT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      long_q  <= 1'b0;
    end else begin
      if (phase_q == PH_IDLE) begin
        if (load_i) begin
          phase_q <= PH_START;
          cnt_q   <= '0;
          idx_q   <= '0;
          sh_q    <= data_i;
          long_q  <= long_i;
        end
      end else if (tick_i) begin
        cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          unique case (phase_q)
            PH_START: phase_q <= PH_DATA;
            PH_DATA: begin
              if (idx_q == last_idx) phase_q <= PH_STOP;
              else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= sh_q >> 1;
              end
            end
            PH_STOP: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START: tx_o = 1'b0;
      PH_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  assign phase_o    = phase_q;
  assign cnt_o      = cnt_q;
  assign idx_o      = idx_q;
  assign long_o     = long_q;
  assign last_bit_o = (phase_q == PH_DATA) && (idx_q == last_idx);
  // capture edge: tick index 7 -> 8 (mid-bit)
  assign cap_o      = (phase_q == PH_DATA) && tick_i && (cnt_q == CNT_CAP);
  assign done_o     = (phase_q == PH_STOP) && bit_end;

  a_r10_cnt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && !tick_i) |=> $stable(cnt_q));
  a_r2_data_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && !bit_end) |=> $stable(tx_o));
endmodule

// File: rtl/sua_clk_gen.sv
module sua_clk_gen
  import sua_pkg::*;
#(
  parameter int OSR = 16,
  localparam int CNT_W = $clog2(OSR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_bit_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lastclk_i,
  output logic             sclk_o
);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2);

  logic first_half;
  logic active;

  assign first_half = (cnt_i < CNT_HALF);
  always_comb begin
    active = 1'b0;
    if (phase_i == PH_DATA) begin
      active = cpha_i ? first_half : !first_half;
      if (last_bit_i && !lastclk_i) active = 1'b0;
    end
  end
  assign sclk_o = cpol_i ^ active;

  a_r6_no_last_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_bit_i && !lastclk_i) |-> (sclk_o == cpol_i));
endmodule

// File: rtl/sua_rx_capture.sv
module sua_rx_capture #(
  parameter int DATA_W = 9,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rx_i,
  input  logic              done_i,
  input  logic              long_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (cap_i) sh_q[idx_i] <= rx_i;
      if (done_i) begin
        data_q  <= long_i ? sh_q : {1'b0, sh_q[DATA_W-2:0]};
        valid_q <= 1'b1;
        ovr_q   <= (ovr_q || valid_q) && !read_i;
      end else if (read_i) begin
        valid_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;

  a_r8_valid_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(done_i));
  a_r9_ovr_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> ($past(valid_q) && $past(done_i)));
endmodule

// File: rtl/sync_usart_master.sv
module sync_usart_master
  import sua_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              cfg_long_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_lastclk_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_read_i,
  output logic              rx_overrun_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              sclk_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             last_bit, long_w, cap, done;

  sua_frame_ctrl #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(baud_tick_i), .load_i(tx_load_i),
    .data_i(tx_data_i), .long_i(cfg_long_i), .phase_o(phase), .cnt_o(cnt),
    .idx_o(idx), .last_bit_o(last_bit), .long_o(long_w), .cap_o(cap),
    .done_o(done), .tx_o(tx_o)
  );

  sua_clk_gen #(.OSR(OSR)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .cnt_i(cnt),
    .last_bit_i(last_bit), .cpol_i(cfg_cpol_i), .cpha_i(cfg_cpha_i),
    .lastclk_i(cfg_lastclk_i), .sclk_o(sclk_o)
  );

  sua_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .idx_i(idx), .rx_i(rx_i),
    .done_i(done), .long_i(long_w), .read_i(rx_read_i), .data_o(rx_data_o),
    .valid_o(rx_valid_o), .overrun_o(rx_overrun_o)
  );

  assign tx_busy_o = (phase != PH_IDLE);

  a_r4_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> (sclk_o == cfg_cpol_i));
  a_r3_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> tx_o);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> !tx_o);
endmodule

// File: tb/sync_usart_master_tb_top.sv
module sync_usart_master_tb_top;
  typedef struct packed {
    logic       l9;
    logic       cpol;
    logic       cpha;
    logic       lc;
    logic [8:0] txd;
    logic [8:0] rxd;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 9'h1A5, 9'h0C3},
    '{1'b0, 1'b0, 1'b1, 1'b1, 9'h05A, 9'h1FF},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'h0F0, 9'h03C},
    '{1'b1, 1'b1, 1'b1, 1'b0, 9'h101, 9'h155},
    '{1'b1, 1'b0, 1'b1, 1'b0, 9'h0AA, 9'h1AA},
    '{1'b0, 1'b1, 1'b1, 1'b1, 9'h181, 9'h07E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, l9 = 1'b0, cpol = 1'b0, cpha = 1'b0, lc = 1'b1;
  logic [8:0] txd = '0;
  logic load = 1'b0, rd = 1'b0, rx = 1'b1;
  logic busy, rxv, ovr, tx, sclk;
  logic [8:0] rxq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sync_usart_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .cfg_long_i(l9),
    .cfg_cpol_i(cpol), .cfg_cpha_i(cpha), .cfg_lastclk_i(lc),
    .tx_data_i(txd), .tx_load_i(load), .tx_busy_o(busy), .rx_data_o(rxq),
    .rx_valid_o(rxv), .rx_read_i(rd), .rx_overrun_o(ovr), .tx_o(tx),
    .rx_i(rx), .sclk_o(sclk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic m_tx(int p, int n, logic [8:0] d);
    int b = p / 16;
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    return 1'b1;
  endfunction

  function automatic logic m_sclk(int p, int n, logic pol, logic ph, logic lastc);
    int b = p / 16;
    int t = p % 16;
    logic act;
    if (b < 1 || b > n) return pol;
    act = ph ? (t < 8) : (t >= 8);
    if (b == n && !lastc) act = 1'b0;
    return pol ^ act;
  endfunction

  // Runs one frame; checks tx/sclk/busy against the model every cycle (R2,R4,R5,R6)
  task automatic run_frame(input vec_t v, input int div, input int mid_load_p);
    int n = v.l9 ? 9 : 8;
    int total = 16 * (n + 2);
    int p = 0;
    int cyc = 0;
    int tx_bad = 0, sc_bad = 0, bz_bad = 0;
    logic a_tx = 1'b0, e_tx = 1'b0, a_sc = 1'b0, e_sc = 1'b0;
    l9 = v.l9; cpol = v.cpol; cpha = v.cpha; lc = v.lc;
    @(negedge clk);
    txd = v.txd; load = 1'b1; tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    while (p < total) begin
      if (tx !== m_tx(p, n, v.txd)) begin
        if (tx_bad == 0) begin a_tx = tx; e_tx = m_tx(p, n, v.txd); end
        tx_bad++;
      end
      if (sclk !== m_sclk(p, n, v.cpol, v.cpha, v.lc)) begin
        if (sc_bad == 0) begin a_sc = sclk; e_sc = m_sclk(p, n, v.cpol, v.cpha, v.lc); end
        sc_bad++;
      end
      if (busy !== 1'b1) bz_bad++;
      tick = (cyc % div) == 0;
      // rx valid only around the capture tick (R7)
      if (p / 16 >= 1 && p / 16 <= n && p % 16 >= 6 && p % 16 <= 8)
        rx = v.rxd[p/16-1];
      else
        rx = ~rx;
      load = (p == mid_load_p) && tick;
      if (load) txd = ~v.txd;
      @(posedge clk);
      @(negedge clk);
      load = 1'b0;
      if (tick) p++;
      cyc++;
    end
    tick = 1'b0;
    rx = 1'b1;
    check(tx_bad == 0, "R2 tx waveform", a_tx, e_tx);
    check(sc_bad == 0, "R5 sclk waveform", a_sc, e_sc);
    check(bz_bad == 0, "R3 busy during frame", bz_bad, 0);
    check(busy == 1'b0 && tx == 1'b1, "R3 idle after frame", {busy, tx}, 2'b01);
    check(sclk == v.cpol, "R4 sclk idle level", sclk, v.cpol);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    vec_t v;
    logic [8:0] e;
    logic [8:0] first;
    repeat (3) @(negedge clk);
    // reset state
    check(tx == 1 && busy == 0 && rxv == 0 && ovr == 0 && sclk == 0,
          "R3 reset state", {tx, busy, rxv, ovr, sclk}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    #1;
    check(sclk == 1'b1, "R4 idle high with cpol", sclk, 1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      run_frame(v, 1, -1);
      e = v.l9 ? v.rxd : {1'b0, v.rxd[7:0]};
      check(rxv == 1'b1, "R8 valid after stop", rxv, 1);
      check(rxq == e, "R7 rx word (R1 width)", rxq, e);
      check(ovr == 1'b0, "R9 no overrun", ovr, 0);
      do_read();
      check(rxv == 1'b0, "R8 read clears valid", rxv, 0);
    end

    // R8: valid rises exactly one cycle after the tick that ends the stop bit
    v = '{1'b0, 1'b0, 1'b0, 1'b1, 9'h033, 9'h0A5};
    l9 = 0; cpol = 0; cpha = 0; lc = 1;
    @(negedge clk);
    txd = v.txd; load = 1'b1; tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    repeat (16 * 10 - 1) @(negedge clk);
    check(rxv == 1'b0, "R8 not valid before last stop tick", rxv, 0);
    @(negedge clk);
    check(rxv == 1'b1 && busy == 1'b0, "R8 valid right after stop", {rxv, busy}, 2'b10);
    tick = 1'b0;
    do_read();

    // R3: load during a frame is ignored
    v = '{1'b1, 1'b0, 1'b1, 1'b1, 9'h0C9, 9'h136};
    run_frame(v, 1, 40);
    check(rxq == 9'h136, "R3 mid-frame load ignored, rx", rxq, 9'h136);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3 no frame started by ignored load", busy, 0);
    do_read();

    // R10: ticks every third cycle
    v = '{1'b1, 1'b1, 1'b0, 1'b0, 9'h15C, 9'h0E7};
    run_frame(v, 3, -1);
    check(rxq == 9'h0E7, "R10 slow tick rx word", rxq, 9'h0E7);
    do_read();

    // R6: suppression with lastclk=0 vs 1 covered by table; R1: bit 8 dropped in 8-bit mode
    v = '{1'b0, 1'b0, 1'b0, 1'b0, 9'h100, 9'h1FF};
    run_frame(v, 1, -1);
    check(rxq == 9'h0FF, "R1 8-bit mode upper bit zero", rxq, 9'h0FF);

    // R9: second word while first unread
    first = rxq;
    v = '{1'b1, 1'b0, 1'b0, 1'b1, 9'h011, 9'h1C6};
    run_frame(v, 1, -1);
    check(ovr == 1'b1, "R9 overrun set", ovr, 1);
    check(rxq == 9'h1C6 && rxq != first, "R9 newer word kept", rxq, 9'h1C6);
    do_read();
    check(ovr == 1'b0 && rxv == 1'b0, "R9 read clears overrun", {ovr, rxv}, 2'b00);

    finish_run();
  end
endmodule